// File: doc/BRIEF.md
# Display RAM Bus Holder Pipeline

This block connects an 8-bit parallel processor bus to a synchronous display RAM. It keeps the processor's access timing separate from the RAM's. Every data access goes through a single holding register. A data write places the byte in the holder, and the RAM takes that byte on the next clock, before any later write. A data read drives the current holder contents onto the bus. The same clock edge then refills the holder from the RAM. As a result, each read returns what the previous read fetched.

The block keeps its own RAM address register. An instruction-type write loads this register. The register advances by one after every committed write and after every read fetch. Because the first read after an address load or after a write returns the old holder contents, software issues one dummy read and then streams consecutive locations. The bus is released (high impedance, shown by a low output-enable) whenever the chip is not selected or no data read is in progress. The RAM is an internal array of `2**ADDR_W` bytes. Reset clears the holder and the address, but it does not clear the RAM.

Top module: `dispram_holder`

## Requirements
- R1: Accesses are acted on only when `sel_n` is 0 and `sel` is 1; a strobe is ignored if either condition fails.
- R2: While deselected, `dout_oe` is 0, and write or read strobes change neither the address, nor the holder, nor the RAM.
- R3: A selected write with `dsel`=0 loads the address register with `din[ADDR_W-1:0]` and leaves the holder unchanged.
- R4: The first data read after an address load returns the holder contents from before the load (a dummy value). It also fills the holder from the newly loaded address.
- R5: After the dummy read, each further data read returns the next consecutive RAM location, and the address advances by one per read.
- R6: A selected data write (`dsel`=1) stores `din` in the holder. One clock later the holder is committed to the RAM at the current address, and the address then advances by one.
- R7: Data writes on consecutive cycles, or a write followed at once by an address load, commit every byte in order to the right locations with no loss.
- R8: A data read issued directly after a write returns the written byte (the holder). The refill comes from the address in force after that write has committed.
- R9: The address wraps from `2**ADDR_W-1` to 0 for both writes and reads.
- R10: After reset the address is 0, no write is pending, `dout_oe` is 0, and the first read returns 0.
- R11: `dout_oe` is 1 only during a selected data read with no write strobe, and `dout` then equals the holder value; instruction reads (`dsel`=0) leave the bus released.
- R12: When write and read strobes are both asserted, the write is performed and the read is ignored (bus stays released).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_n | input | 1 | Active-low chip select |
| sel | input | 1 | Active-high chip select |
| dsel | input | 1 | 1 = data access, 0 = instruction (address load) |
| wr_stb | input | 1 | Write strobe, one cycle per access |
| rd_stb | input | 1 | Read strobe, one cycle per access |
| din | input | 8 | Bus write data |
| dout | output | 8 | Bus read data, 0 when not driven |
| dout_oe | output | 1 | Bus drive enable; 0 means high impedance |

## Verification
The RAM is first filled by one unbroken burst of back-to-back writes. A read issued straight after that burst wraps across the top of the address space, which separates correct commit ordering and wrap-around from lost or misplaced bytes. Every start address is then loaded in turn and followed by a dummy read and three streamed reads. This shows whether the dummy value is the old holder contents and whether the stream starts at the right location. Write-then-read, write-then-address-load, simultaneous strobes, instruction reads and deselected strobes under each failing select combination are each followed by reads that expose any change to the address, the holder or the RAM.

// File: rtl/dh_pkg.sv
package dh_pkg;

    localparam int DATA_W = 8;

    typedef logic [DATA_W-1:0] byte_t;

    typedef enum logic [1:0] {
        ACC_IDLE    = 2'd0,
        ACC_SETADDR = 2'd1,
        ACC_WDATA   = 2'd2,
        ACC_RDATA   = 2'd3
    } acc_e;

    // Write has priority over read; instruction reads are not handled here.
    function automatic acc_e decode_access(input logic sel_n, input logic sel,
                                           input logic dsel, input logic wr,
                                           input logic rd);
        if (sel_n || !sel) return ACC_IDLE;
        if (wr)            return dsel ? ACC_WDATA : ACC_SETADDR;
        if (rd && dsel)    return ACC_RDATA;
        return ACC_IDLE;
    endfunction

endpackage

// File: rtl/dh_decode.sv
module dh_decode
    import dh_pkg::*;
(
    input  logic sel_n,
    input  logic sel,
    input  logic dsel,
    input  logic wr_stb,
    input  logic rd_stb,
    output acc_e acc,
    output logic drive
);
    always_comb begin
        acc   = decode_access(sel_n, sel, dsel, wr_stb, rd_stb);
        drive = (acc == ACC_RDATA);
    end
endmodule

// File: rtl/dh_addr.sv
module dh_addr
    import dh_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  acc_e              acc,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              pend,
    output logic [ADDR_W-1:0] addr_q,
    output logic [ADDR_W-1:0] fetch_addr
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1);

    // A pending commit consumes the current address before any fetch.
    always_comb fetch_addr = pend ? addr_q + STEP : addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
        end else if (acc == ACC_SETADDR) begin
            addr_q <= load_val;
        end else if (acc == ACC_RDATA) begin
            addr_q <= fetch_addr + STEP;
        end else if (pend) begin
            addr_q <= addr_q + STEP;
        end
    end
endmodule

// File: rtl/dh_holder.sv
module dh_holder
    import dh_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  acc_e  acc,
    input  byte_t wr_byte,
    input  byte_t ram_byte,
    output byte_t hold_q,
    output logic  pend_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
            pend_q <= 1'b0;
        end else begin
            unique case (acc)
                ACC_WDATA: begin
                    hold_q <= wr_byte;
                    pend_q <= 1'b1;
                end
                ACC_RDATA: begin
                    hold_q <= ram_byte;
                    pend_q <= 1'b0;
                end
                default: pend_q <= 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/dh_ram.sv
module dh_ram
    import dh_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  byte_t             wdata,
    input  logic [ADDR_W-1:0] raddr,
    output byte_t             rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    byte_t mem [DEPTH];

    // Read data is registered by the holder, giving a synchronous read.
    always_comb rdata = mem[raddr];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end
endmodule

// File: rtl/dispram_holder.sv
module dispram_holder
    import dh_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        sel_n,
    input  logic        sel,
    input  logic        dsel,
    input  logic        wr_stb,
    input  logic        rd_stb,
    input  logic [7:0]  din,
    output logic [7:0]  dout,
    output logic        dout_oe
);
    acc_e              acc;
    logic              drive;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] fetch_addr;
    byte_t             hold_q;
    byte_t             ram_byte;
    logic              pend_q;

    dh_decode u_dec (
        .sel_n (sel_n),
        .sel   (sel),
        .dsel  (dsel),
        .wr_stb(wr_stb),
        .rd_stb(rd_stb),
        .acc   (acc),
        .drive (drive)
    );

    dh_addr #(.ADDR_W(ADDR_W)) u_addr (
        .clk       (clk),
        .rst       (rst),
        .acc       (acc),
        .load_val  (din[ADDR_W-1:0]),
        .pend      (pend_q),
        .addr_q    (addr_q),
        .fetch_addr(fetch_addr)
    );

    dh_holder u_hold (
        .clk     (clk),
        .rst     (rst),
        .acc     (acc),
        .wr_byte (din),
        .ram_byte(ram_byte),
        .hold_q  (hold_q),
        .pend_q  (pend_q)
    );

    dh_ram #(.ADDR_W(ADDR_W)) u_ram (
        .clk  (clk),
        .we   (pend_q),
        .waddr(addr_q),
        .wdata(hold_q),
        .raddr(fetch_addr),
        .rdata(ram_byte)
    );

    always_comb begin
        dout_oe = drive;
        dout    = drive ? hold_q : '0;
    end
endmodule

// File: rtl/dispram_holder_chk.sv
module dispram_holder_chk #(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              sel_n,
    input logic              sel,
    input logic              dsel,
    input logic              wr_stb,
    input logic              rd_stb,
    input logic              dout_oe,
    input logic [ADDR_W-1:0] set_val,
    input logic [ADDR_W-1:0] addr,
    input logic              pend,
    input logic [7:0]        holder
);
    logic on;
    always_comb on = !sel_n && sel;

    AST_DESEL_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
        !on |-> !dout_oe); // R2
    AST_OE_READ_ONLY: assert property (@(posedge clk) disable iff (rst)
        dout_oe |-> (rd_stb && dsel && !wr_stb)); // R11
    AST_ADDR_LOAD: assert property (@(posedge clk) disable iff (rst)
        (on && wr_stb && !dsel) |=> addr == $past(set_val)); // R3
    AST_WRITE_PENDS: assert property (@(posedge clk) disable iff (rst)
        (on && wr_stb && dsel) |=> pend); // R6
    AST_PEND_DRAINS: assert property (@(posedge clk) disable iff (rst)
        (pend && !(on && wr_stb && dsel)) |=> !pend); // R7
    AST_HOLDER_IDLE: assert property (@(posedge clk) disable iff (rst)
        !(on && dsel && (wr_stb || rd_stb)) |=> $stable(holder)); // R2
    AST_READ_STEP: assert property (@(posedge clk) disable iff (rst)
        (on && rd_stb && dsel && !wr_stb && !pend)
            |=> (addr - $past(addr)) == ADDR_W'(1)); // R5
    AST_COMMIT_STEP: assert property (@(posedge clk) disable iff (rst)
        (pend && !(on && (wr_stb || (rd_stb && dsel))))
            |=> (addr - $past(addr)) == ADDR_W'(1)); // R6
    AST_DESEL_ADDR: assert property (@(posedge clk) disable iff (rst)
        (!on && !pend) |=> $stable(addr)); // R1
endmodule

bind dispram_holder dispram_holder_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .sel_n  (sel_n),
    .sel    (sel),
    .dsel   (dsel),
    .wr_stb (wr_stb),
    .rd_stb (rd_stb),
    .dout_oe(dout_oe),
    .set_val(din[ADDR_W-1:0]),
    .addr   (addr_q),
    .pend   (pend_q),
    .holder (hold_q)
);

// File: tb/tb_dispram_holder.sv
module tb_dispram_holder;
    localparam int AW    = 6;
    localparam int DEPTH = 1 << AW;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sel_n = 1'b1, sel = 1'b0, dsel = 1'b0, wr_stb = 1'b0, rd_stb = 1'b0;
    logic [7:0] din = '0;
    logic [7:0] dout;
    logic       dout_oe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dispram_holder #(.ADDR_W(AW)) dut (
        .clk(clk), .rst(rst), .sel_n(sel_n), .sel(sel), .dsel(dsel),
        .wr_stb(wr_stb), .rd_stb(rd_stb), .din(din), .dout(dout), .dout_oe(dout_oe)
    );

    function automatic logic [7:0] pat(input int i);
        return 8'(((i % DEPTH) * 37 + 5) & 255);
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One bus cycle: drive at the falling edge, sample, then pass the rising edge.
    task automatic cyc(input logic sn, input logic s, input logic ds, input logic w,
                       input logic r, input logic [7:0] d,
                       output logic [7:0] q, output logic o);
        @(negedge clk);
        sel_n = sn; sel = s; dsel = ds; wr_stb = w; rd_stb = r; din = d;
        #1;
        q = dout; o = dout_oe;
        @(posedge clk);
    endtask

    task automatic set_addr(input int a);
        logic [7:0] q; logic o;
        cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8'(a), q, o);
    endtask

    task automatic wr_data(input logic [7:0] d);
        logic [7:0] q; logic o;
        cyc(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, d, q, o);
    endtask

    task automatic rd_expect(input string req, input logic [7:0] exp);
        logic [7:0] q; logic o;
        cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 8'h00, q, o);
        chk({req, " oe"}, {7'd0, o}, 8'd1);
        chk(req, q, exp);
    endtask

    task automatic idle_oe(input string req);
        logic [7:0] q; logic o;
        cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, q, o);
        chk(req, {7'd0, o}, 8'd0);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] q; logic o;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R10: reset state
        idle_oe("R10 idle bus");
        rd_expect("R10 first read", 8'h00);

        // R7: fill the RAM by one back-to-back burst
        set_addr(0);
        for (int i = 0; i < DEPTH; i++) wr_data(pat(i));
        // R8: read right after write returns the holder; R9: wrapped fetch
        rd_expect("R8 read after write", pat(DEPTH - 1));
        rd_expect("R9 wrap to 0", pat(0));
        rd_expect("R5 stream", pat(1));

        // R4, R5, R3: every start address
        for (int s = 0; s < DEPTH; s++) begin
            set_addr(s);
            rd_expect("R4 dummy", (s == 0) ? pat(2) : pat(s + 2));
            rd_expect("R4 first data", pat(s));
            rd_expect("R5 next", pat(s + 1));
            rd_expect("R5 next2", pat(s + 2));
        end
        // holder now holds pat(DEPTH+2) = pat(2)

        // R6, R8: write then read without dummy
        set_addr(10);
        wr_data(8'hA5);
        rd_expect("R8 holder after write", 8'hA5);
        rd_expect("R8 fetch after commit", pat(11));
        set_addr(10);
        rd_expect("R6 dummy", pat(12));
        rd_expect("R6 committed at address", 8'hA5);

        // R7: write then immediate address load
        wr_data(8'h11);
        set_addr(40);
        rd_expect("R7 dummy holds write", 8'h11);
        rd_expect("R7 new address data", pat(40));
        set_addr(12);
        rd_expect("R7 dummy2", pat(41));
        rd_expect("R7 committed before load", 8'h11);

        // R1, R2: deselected strobes under each failing select combination
        set_addr(20);
        rd_expect("R2 dummy", pat(13));
        rd_expect("R2 setup", pat(20));
        cyc(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 8'hFF, q, o);
        chk("R2 oe on desel write", {7'd0, o}, 8'd0);
        cyc(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h05, q, o);
        chk("R1 oe on desel addr", {7'd0, o}, 8'd0);
        cyc(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 8'h00, q, o);
        chk("R2 oe on desel read", {7'd0, o}, 8'd0);
        cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'h00, q, o);
        chk("R1 oe on half select", {7'd0, o}, 8'd0);
        rd_expect("R1 holder untouched", pat(21));
        rd_expect("R2 address untouched", pat(22));
        set_addr(20);
        rd_expect("R2 dummy3", pat(23));
        rd_expect("R2 RAM untouched", pat(20));

        // R12: simultaneous strobes
        set_addr(30);
        cyc(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 8'h3C, q, o);
        chk("R12 no drive", {7'd0, o}, 8'd0);
        rd_expect("R12 write taken", 8'h3C);
        rd_expect("R12 next", pat(31));

        // R11: instruction read leaves bus released and state alone
        cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'h00, q, o);
        chk("R11 instr read no drive", {7'd0, o}, 8'd0);
        rd_expect("R11 stream unaffected", pat(32));
        set_addr(30);
        rd_expect("R12 dummy", pat(33));
        rd_expect("R12 RAM holds write", 8'h3C);

        idle_oe("R11 idle release");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule